// File: doc/BRIEF.md
# Two-Wire Bus Slave Status Tracker

This block listens to a two-wire serial bus (a clock line and a data line, both open-drain and idle high) from inside a faster system clock domain and keeps a status word that a host can read. Both lines are resynchronized. Start and stop conditions are then recognised, the clock pulses of each byte are counted, and the first byte after every start is read as a calling address followed by a direction bit.

The tracker compares the calling address with a programmed own address. When broadcast mode is enabled, it also compares it with the all-zeros broadcast address. It records the acknowledge bit of each byte and can raise an interrupt request when the device has been addressed. The host clears the address-related flags by writing its control register, and it clears the sticky arbitration-lost flag with a separate strobe.

The block only observes the bus. It never drives the data line and never stretches the clock.

Top module: `twi_status_tracker`

## Requirements
- R1: `busy` becomes 1 after a start condition (data falling while clock is high) and becomes 0 after a stop condition (data rising while clock is high).
- R2: `xfer_done` is 0 from a start condition and from the first rising clock of each byte, through the ninth rising clock. It becomes 1 after the falling edge of the ninth clock of the byte.
- R3: After the address byte, `addressed` is 1 when the seven address bits (sent MSB first, bits 7..1 of the first byte) equal a nonzero `own_addr`. Otherwise it is 0, unless R5 applies.
- R4: A one-cycle pulse on `ctrl_wr` clears both `addressed` and `bcast_hit`.
- R5: An all-zeros address with `bcast_en`=1 sets both `addressed` and `bcast_hit`. With `bcast_en`=0, the same address sets neither flag.
- R6: `slave_rw` holds bit 0 of the address byte: 0 means the master writes, 1 means the master reads.
- R7: `arb_flag` is set by `arb_lost` and stays set through bus traffic and `ctrl_wr`. Only `arb_clr` clears it, and a set on the same cycle wins.
- R8: After reset, every flag output is 0 except `rx_nack`, which is 1, and `irq` is 0.
- R9: `irq` equals `irq_en` AND `addressed`.
- R10: `rx_nack` takes the data line value sampled at the ninth rising clock of each byte (1 means no acknowledge).
- R11: A repeated start (a start condition while `busy` is 1) keeps `busy` at 1, restarts bit counting, and evaluates the following byte as a new address.
- R12: Bytes after the first byte following a start never change `addressed`, `bcast_hit` or `slave_rw`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| own_addr | input | ADDR_W | Programmed own slave address |
| bcast_en | input | 1 | Enables matching of the all-zeros address |
| irq_en | input | 1 | Enables the interrupt request |
| ctrl_wr | input | 1 | Host control-register write strobe |
| arb_lost | input | 1 | Arbitration-lost event pulse |
| arb_clr | input | 1 | Host clear of the arbitration-lost flag |
| busy | output | 1 | Bus busy flag |
| xfer_done | output | 1 | Byte transfer complete flag |
| addressed | output | 1 | Addressed-as-slave flag |
| bcast_hit | output | 1 | Broadcast address match flag |
| slave_rw | output | 1 | Direction bit of the last calling address |
| arb_flag | output | 1 | Sticky arbitration-lost flag |
| rx_nack | output | 1 | Last received acknowledge bit (1 = none) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the tracker with SYNC_STAGES=3 and the default ADDR_W=7. It drives the bus with half-periods of eight system clocks. The deeper synchronizer shows that flag timing does not rely on a fixed input latency: every check waits for the bus phase rather than counting exact edges. The default address width makes the nonzero own address, the all-zeros broadcast address and the data-byte decoy value all reachable with real bus bytes.

// File: rtl/twi_pkg.sv
// Shared types for the two-wire status tracker.
package twi_pkg;

    // Status flags kept for the host
    typedef struct packed {
        logic busy;
        logic done;
        logic addressed;
        logic bcast;
        logic rw;
        logic arb;
        logic nack;
    } twi_flags_t;

    localparam twi_flags_t FLAGS_RST = '{busy: 1'b0, done: 1'b0, addressed: 1'b0,
                                         bcast: 1'b0, rw: 1'b0, arb: 1'b0, nack: 1'b1};

endpackage

// File: rtl/twi_line_sync.sv
// Resynchronizes the clock and data lines into clk and derives start, stop
// and clock-edge events from the synchronized values.
// Assumes both lines idle high and change far slower than clk.
module twi_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    localparam int LINES = 2;

    logic [LINES-1:0] line_in;
    logic [LINES-1:0] line_s;
    logic [LINES-1:0] line_q;

    assign line_in = {sda_in, scl_in};

    genvar g;
    generate
        for (g = 0; g < LINES; g++) begin : g_line
            logic [SYNC_STAGES-1:0] chain;
            // Shift the pad value through the synchronizer chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[SYNC_STAGES-2:0], line_in[g]};
            end
            assign line_s[g] = chain[SYNC_STAGES-1];
        end
    endgenerate

    // Hold the previous synchronized values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '1;
        else        line_q <= line_s;
    end

    assign sda_s     = line_s[1];
    assign scl_rise  = line_s[0] & ~line_q[0];
    assign scl_fall  = ~line_s[0] & line_q[0];
    assign start_evt = line_s[0] & line_q[0] & line_q[1] & ~line_s[1];
    assign stop_evt  = line_s[0] & line_q[0] & ~line_q[1] & line_s[1];

endmodule

// File: rtl/twi_bit_framer.sv
// Counts clock pulses within each byte and emits registered one-cycle
// events: byte start, captured address, acknowledge sample, byte done.
// Assumes edge events from twi_line_sync; ignores clocks outside a frame.
module twi_bit_framer #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    output logic              byte_begin,
    output logic              addr_evt,
    output logic [ADDR_W-1:0] addr_val,
    output logic              rw_val,
    output logic              ack_evt,
    output logic              ack_val,
    output logic              byte_done
);
    localparam int DATA_BITS = ADDR_W + 1;
    localparam int LAST_CNT  = DATA_BITS + 1;
    localparam int CNT_W     = $clog2(LAST_CNT + 1);

    logic [CNT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] shreg;
    logic              first_byte;
    logic              active;

    // Track frame position and emit byte-level events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            first_byte <= 1'b0;
            active     <= 1'b0;
            byte_begin <= 1'b0;
            addr_evt   <= 1'b0;
            addr_val   <= '0;
            rw_val     <= 1'b0;
            ack_evt    <= 1'b0;
            ack_val    <= 1'b1;
            byte_done  <= 1'b0;
        end else begin
            byte_begin <= 1'b0;
            addr_evt   <= 1'b0;
            ack_evt    <= 1'b0;
            byte_done  <= 1'b0;
            if (start_evt) begin
                bit_cnt    <= '0;
                first_byte <= 1'b1;
                active     <= 1'b1;
            end else if (stop_evt) begin
                bit_cnt <= '0;
                active  <= 1'b0;
            end else if (active && scl_rise && bit_cnt < CNT_W'(LAST_CNT)) begin
                if (bit_cnt == '0) byte_begin <= 1'b1;
                if (bit_cnt < CNT_W'(ADDR_W)) begin
                    shreg <= {shreg[ADDR_W-2:0], sda_s};
                end else if (bit_cnt == CNT_W'(ADDR_W)) begin
                    if (first_byte) begin
                        addr_evt <= 1'b1;
                        addr_val <= shreg;
                        rw_val   <= sda_s;
                    end
                end else begin
                    ack_evt <= 1'b1;
                    ack_val <= sda_s;
                end
                bit_cnt <= bit_cnt + 1'b1;
            end else if (active && scl_fall && bit_cnt == CNT_W'(LAST_CNT)) begin
                byte_done  <= 1'b1;
                bit_cnt    <= '0;
                first_byte <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/twi_flag_bank.sv
// Holds the host-visible status flags and updates them from bus events
// and host strobes. Assumes events are one-cycle pulses.
module twi_flag_bank #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              byte_begin,
    input  logic              byte_done,
    input  logic              addr_evt,
    input  logic [ADDR_W-1:0] addr_val,
    input  logic              rw_val,
    input  logic              ack_evt,
    input  logic              ack_val,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              bcast_en,
    input  logic              ctrl_wr,
    input  logic              arb_lost,
    input  logic              arb_clr,
    output twi_pkg::twi_flags_t flags
);
    import twi_pkg::*;

    logic zero_addr;
    logic own_hit;
    logic bcast_now;

    // Classify the captured address
    always_comb begin
        zero_addr = (addr_val == '0);
        own_hit   = !zero_addr && (addr_val == own_addr);
        bcast_now = zero_addr && bcast_en;
    end

    // Update each flag from its events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= FLAGS_RST;
        end else begin
            if (start_evt)     flags.busy <= 1'b1;
            else if (stop_evt) flags.busy <= 1'b0;

            if (byte_done)                    flags.done <= 1'b1;
            else if (start_evt || byte_begin) flags.done <= 1'b0;

            if (addr_evt) begin
                flags.addressed <= own_hit || bcast_now;
                flags.bcast     <= bcast_now;
                flags.rw        <= rw_val;
            end else if (ctrl_wr) begin
                flags.addressed <= 1'b0;
                flags.bcast     <= 1'b0;
            end

            if (arb_lost)     flags.arb <= 1'b1;
            else if (arb_clr) flags.arb <= 1'b0;

            if (ack_evt) flags.nack <= ack_val;
        end
    end

endmodule

// File: rtl/twi_status_tracker.sv
// Top level: observes a two-wire bus and presents slave status flags.
// Assumes clk is several times faster than the bus clock; never drives the bus.
module twi_status_tracker #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              bcast_en,
    input  logic              irq_en,
    input  logic              ctrl_wr,
    input  logic              arb_lost,
    input  logic              arb_clr,
    output logic              busy,
    output logic              xfer_done,
    output logic              addressed,
    output logic              bcast_hit,
    output logic              slave_rw,
    output logic              arb_flag,
    output logic              rx_nack,
    output logic              irq
);
    import twi_pkg::*;

    logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic              byte_begin, addr_evt, rw_val, ack_evt, ack_val, byte_done;
    logic [ADDR_W-1:0] addr_val;
    twi_flags_t        flags;

    twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    twi_bit_framer #(.ADDR_W(ADDR_W)) u_framer (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_begin(byte_begin), .addr_evt(addr_evt), .addr_val(addr_val),
        .rw_val(rw_val), .ack_evt(ack_evt), .ack_val(ack_val),
        .byte_done(byte_done)
    );

    twi_flag_bank #(.ADDR_W(ADDR_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
        .byte_begin(byte_begin), .byte_done(byte_done), .addr_evt(addr_evt),
        .addr_val(addr_val), .rw_val(rw_val), .ack_evt(ack_evt),
        .ack_val(ack_val), .own_addr(own_addr), .bcast_en(bcast_en),
        .ctrl_wr(ctrl_wr), .arb_lost(arb_lost), .arb_clr(arb_clr),
        .flags(flags)
    );

    // Map flags to ports and form the interrupt request
    always_comb begin
        busy      = flags.busy;
        xfer_done = flags.done;
        addressed = flags.addressed;
        bcast_hit = flags.bcast;
        slave_rw  = flags.rw;
        arb_flag  = flags.arb;
        rx_nack   = flags.nack;
        irq       = irq_en && flags.addressed;
    end

endmodule

// File: rtl/twi_status_checker.sv
// Protocol checks for twi_status_tracker, attached by bind.
module twi_status_checker (
    input logic clk,
    input logic rst_n,
    input logic start_evt,
    input logic stop_evt,
    input logic byte_done,
    input logic addr_evt,
    input logic ctrl_wr,
    input logic arb_clr,
    input logic irq_en,
    input logic busy,
    input logic xfer_done,
    input logic addressed,
    input logic bcast_hit,
    input logic arb_flag,
    input logic irq
);
    a_r1_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> busy);
    a_r1_stop_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !busy);
    a_r2_done_after_byte: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> xfer_done);
    a_r4_ctrl_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !addr_evt) |=> (!addressed && !bcast_hit));
    a_r5_bcast_implies_addr: assert property (@(posedge clk) disable iff (!rst_n)
        bcast_hit |-> addressed);
    a_r7_arb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_flag && !arb_clr) |=> arb_flag);
    a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (addressed && irq_en));
endmodule

bind twi_status_tracker twi_status_checker u_chk (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .stop_evt(stop_evt),
    .byte_done(byte_done), .addr_evt(addr_evt), .ctrl_wr(ctrl_wr),
    .arb_clr(arb_clr), .irq_en(irq_en), .busy(busy), .xfer_done(xfer_done),
    .addressed(addressed), .bcast_hit(bcast_hit), .arb_flag(arb_flag),
    .irq(irq)
);

// File: tb/sim_twi_status_tracker.sv
module sim_twi_status_tracker;
    localparam int HP  = 8;
    localparam int AW  = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda = 1'b1;
    logic [AW-1:0] own_addr = 7'h5A;
    logic bcast_en = 1'b0, irq_en = 1'b0, ctrl_wr = 1'b0;
    logic arb_lost = 1'b0, arb_clr = 1'b0;
    logic busy, xfer_done, addressed, bcast_hit, slave_rw, arb_flag, rx_nack, irq;
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    twi_status_tracker #(.ADDR_W(AW), .SYNC_STAGES(3)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
        .own_addr(own_addr), .bcast_en(bcast_en), .irq_en(irq_en),
        .ctrl_wr(ctrl_wr), .arb_lost(arb_lost), .arb_clr(arb_clr),
        .busy(busy), .xfer_done(xfer_done), .addressed(addressed),
        .bcast_hit(bcast_hit), .slave_rw(slave_rw), .arb_flag(arb_flag),
        .rx_nack(rx_nack), .irq(irq)
    );

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic wt();
        repeat (HP) @(negedge clk);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1'b1;
        @(negedge clk); s = 1'b0;
        wt();
    endtask

    task automatic bus_start();
        sda = 1'b0; wt(); scl = 1'b0; wt();
    endtask

    task automatic bus_rstart();
        sda = 1'b1; wt(); scl = 1'b1; wt(); sda = 1'b0; wt(); scl = 1'b0; wt();
    endtask

    task automatic bus_stop();
        sda = 1'b0; wt(); scl = 1'b1; wt(); sda = 1'b1; wt(); wt();
    endtask

    task automatic bus_bit(input logic b);
        sda = b; wt(); scl = 1'b1; wt(); scl = 1'b0;
    endtask

    // One byte MSB first plus acknowledge; checks R2 before the ninth fall
    task automatic bus_byte(input logic [7:0] v, input logic ack);
        for (int i = 7; i >= 0; i--) bus_bit(v[i]);
        sda = ack; wt(); scl = 1'b1; wt();
        chk(xfer_done, 1'b0, "R2 low before ninth fall");
        scl = 1'b0; wt(); wt();
        chk(xfer_done, 1'b1, "R2 set after ninth fall");
    endtask

    task automatic t_reset();
        chk(busy, 1'b0, "R8 busy"); chk(xfer_done, 1'b0, "R8 done");
        chk(addressed, 1'b0, "R8 addressed"); chk(bcast_hit, 1'b0, "R8 bcast");
        chk(slave_rw, 1'b0, "R8 rw"); chk(arb_flag, 1'b0, "R8 arb");
        chk(rx_nack, 1'b1, "R8 nack"); chk(irq, 1'b0, "R8 irq");
    endtask

    task automatic t_own_write();
        irq_en = 1'b1;
        bus_start();
        chk(busy, 1'b1, "R1 busy after start");
        chk(irq, 1'b0, "R9 irq before address");
        bus_byte({7'h5A, 1'b0}, 1'b0);
        chk(addressed, 1'b1, "R3 own match");
        chk(bcast_hit, 1'b0, "R3 no bcast");
        chk(slave_rw, 1'b0, "R6 write dir");
        chk(rx_nack, 1'b0, "R10 ack seen");
        chk(irq, 1'b1, "R9 irq raised");
        irq_en = 1'b0; wt();
        chk(irq, 1'b0, "R9 irq masked");
    endtask

    task automatic t_clear_stop();
        pulse(ctrl_wr);
        chk(addressed, 1'b0, "R4 ctrl clears addressed");
        bus_stop();
        chk(busy, 1'b0, "R1 busy after stop");
    endtask

    task automatic t_mismatch_read();
        bus_start();
        bus_byte({7'h33, 1'b1}, 1'b1);
        chk(addressed, 1'b0, "R3 mismatch");
        chk(slave_rw, 1'b1, "R6 read dir");
        chk(rx_nack, 1'b1, "R10 nack seen");
        bus_stop();
    endtask

    task automatic t_bcast_on();
        bcast_en = 1'b1;
        bus_start();
        bus_byte(8'h00, 1'b0);
        chk(addressed, 1'b1, "R5 bcast addressed");
        chk(bcast_hit, 1'b1, "R5 bcast hit");
        pulse(ctrl_wr);
        chk(addressed, 1'b0, "R4 clear addressed");
        chk(bcast_hit, 1'b0, "R4 clear bcast");
        bus_stop();
    endtask

    task automatic t_bcast_off();
        bcast_en = 1'b0;
        bus_start();
        bus_byte(8'h00, 1'b0);
        chk(addressed, 1'b0, "R5 disabled addressed");
        chk(bcast_hit, 1'b0, "R5 disabled bcast");
        bus_stop();
    endtask

    task automatic t_rstart();
        bus_start();
        bus_byte({7'h11, 1'b0}, 1'b0);
        chk(addressed, 1'b0, "R11 first address miss");
        bus_rstart();
        chk(busy, 1'b1, "R11 busy kept");
        bus_byte({7'h5A, 1'b1}, 1'b0);
        chk(addressed, 1'b1, "R11 new address");
        chk(slave_rw, 1'b1, "R11 read dir");
        bus_stop();
        pulse(ctrl_wr);
    endtask

    task automatic t_data_byte();
        bus_start();
        bus_byte({7'h5A, 1'b1}, 1'b0);
        pulse(ctrl_wr);
        bus_byte({7'h5A, 1'b0}, 1'b1);
        chk(addressed, 1'b0, "R12 data byte ignored");
        chk(slave_rw, 1'b1, "R12 rw kept");
        chk(rx_nack, 1'b1, "R10 data nack");
        bus_stop();
    endtask

    task automatic t_arb();
        pulse(arb_lost);
        chk(arb_flag, 1'b1, "R7 set");
        pulse(ctrl_wr);
        bus_start(); bus_byte(8'h22, 1'b0); bus_stop();
        chk(arb_flag, 1'b1, "R7 sticky");
        @(negedge clk); arb_lost = 1'b1; arb_clr = 1'b1;
        @(negedge clk); arb_lost = 1'b0; arb_clr = 1'b0; wt();
        chk(arb_flag, 1'b1, "R7 set wins");
        pulse(arb_clr);
        chk(arb_flag, 1'b0, "R7 cleared");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        wt();
        t_reset();
        t_own_write();
        t_clear_stop();
        t_mismatch_read();
        t_bcast_on();
        t_bcast_off();
        t_rstart();
        t_data_byte();
        t_arb();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule